// File: doc/BRIEF.md
# DMA Channel Event Interrupt Controller

This block gathers the per-channel event pulses that the engines of a multi-channel DMA controller produce and turns them into one interrupt line. There are four event classes. Two are completion classes: one for the end of a whole transfer chain and one for the end of a single chained node. The other two are error classes. Each class keeps a sticky pending vector and an enable vector, with one bit per channel. The block exposes an enabled (masked) view of each class and a per-channel summary that shows whether a channel has any enabled event pending.

Software reaches the block through a simple register port. Writes take effect on a clock edge and reads are combinational. Software enables a class by writing its enable register. It clears events by writing ones to the class's pending register. The two completion classes are fully independent, so a channel can have both pending at once and each is cleared separately.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset every pending bit and every enable bit is zero, every register reads zero, and `irq_o` is low.
- R2: A one-cycle pulse on bit k of an event input sets pending bit k of that class. The bit can be read at the class's pending address (chain 0x600, node 0x608, error-A 0x610, error-B 0x618) from the cycle after the pulse, whatever the enable state.
- R3: A write to an enable address (chain 0x018, node 0x01C, error-A 0x020, error-B 0x024) loads the low NUM_CH data bits. That value reads back at the same address and is held until the next write there.
- R4: The enabled view of a class (chain 0x004, node 0x008, error-A 0x00C, error-B 0x010) reads as that class's pending bits AND its enable bits.
- R5: A write to a pending address clears each pending bit whose data bit is 1. Bits written 0 keep their value.
- R6: If an event pulse and a clearing write hit the same pending bit in the same cycle, the bit ends set.
- R7: The summary register at 0x000 holds, per channel bit, the OR of the four enabled views.
- R8: `irq_o` is high exactly when at least one enabled pending bit exists in any class.
- R9: Clearing one class leaves the pending bits of every other class unchanged. This holds in particular for chain and node completion on the same channel.
- R10: Writes to read-only addresses (0x000 to 0x010) and to unmapped addresses change no state. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_chain_i | input | NUM_CH | Per-channel chain-complete event pulses |
| ev_node_i | input | NUM_CH | Per-channel node-complete event pulses |
| ev_err_a_i | input | NUM_CH | Per-channel error class A pulses |
| ev_err_b_i | input | NUM_CH | Per-channel error class B pulses |
| reg_addr_i | input | 12 | Register byte address |
| reg_wen_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | NUM_CH | Write data, one bit per channel |
| reg_rdata_o | output | DATA_W | Combinational read data, zero-extended |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach from the ports is an event pulse and a clearing write to the same bit arriving on the same clock edge. Other bits of the same write must still clear in that cycle. The bench drives both on one falling edge, with a write mask that covers both the colliding bit and a neighbour, and then checks that only the neighbour cleared. The summary and interrupt logic is swept exhaustively on a four-channel build: every pending pattern is combined with every enable pattern in each class, and a cross-class case checks that the summary ORs the classes.

// File: rtl/dma_irq_pkg.sv
// Shared constants and address helpers for the DMA event interrupt controller.
// Assumes a 12-bit byte address space; offsets are fixed by software decode.
package dma_irq_pkg;
    localparam int NUM_CLASS = 4;
    localparam int ADDR_W    = 12;

    typedef enum logic [1:0] {
        CLS_CHAIN = 2'd0,
        CLS_NODE  = 2'd1,
        CLS_ERR_A = 2'd2,
        CLS_ERR_B = 2'd3
    } ev_class_e;

    localparam logic [ADDR_W-1:0] OFS_SUMMARY = 12'h000;

    // Address of the enabled (masked) view of class c
    function automatic logic [ADDR_W-1:0] view_ofs(input int c);
        return ADDR_W'(12'h004 + 4 * c);
    endfunction

    // Address of the enable register of class c
    function automatic logic [ADDR_W-1:0] enable_ofs(input int c);
        return ADDR_W'(12'h018 + 4 * c);
    endfunction

    // Address of the pending / write-one-to-clear register of class c
    function automatic logic [ADDR_W-1:0] pending_ofs(input int c);
        return ADDR_W'(12'h600 + 8 * c);
    endfunction
endpackage

// File: rtl/dma_irq_class.sv
// One event class: a sticky pending vector, an enable vector and the
// enabled view. Assumes at most one write strobe per class per cycle.
// A new event beats a simultaneous clear of the same bit.
module dma_irq_class #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ev_i,
    input  logic              en_we_i,
    input  logic              clr_we_i,
    input  logic [NUM_CH-1:0] wdata_i,
    output logic [NUM_CH-1:0] pend_o,
    output logic [NUM_CH-1:0] en_o,
    output logic [NUM_CH-1:0] view_o
);
    logic [NUM_CH-1:0] pend_q;
    logic [NUM_CH-1:0] en_q;
    logic [NUM_CH-1:0] clr_bits;

    // Bits to clear this cycle, from a write-one-to-clear access
    always_comb clr_bits = clr_we_i ? wdata_i : '0;

    // Pending vector: set by events, cleared by software, events win
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_bits) | ev_i;
    end

    // Enable vector: loaded by software writes
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (en_we_i) en_q <= wdata_i;
    end

    assign pend_o = pend_q;
    assign en_o   = en_q;
    assign view_o = pend_q & en_q;
endmodule

// File: rtl/dma_irq_regif.sv
// Register decode and read multiplexer. Produces one-hot write strobes for
// the enable and pending registers of each class; read-only and unmapped
// addresses produce no strobe. Reads are combinational and zero-extended.
module dma_irq_regif
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0]                   addr_i,
    input  logic                                wen_i,
    input  logic [NUM_CLASS-1:0][NUM_CH-1:0]    pend_i,
    input  logic [NUM_CLASS-1:0][NUM_CH-1:0]    en_i,
    input  logic [NUM_CLASS-1:0][NUM_CH-1:0]    view_i,
    input  logic [NUM_CH-1:0]                   summary_i,
    output logic [NUM_CLASS-1:0]                en_we_o,
    output logic [NUM_CLASS-1:0]                clr_we_o,
    output logic [DATA_W-1:0]                   rdata_o
);
    // Write strobe decode, one class at a time
    always_comb begin
        for (int c = 0; c < NUM_CLASS; c++) begin
            en_we_o[c]  = wen_i && (addr_i == enable_ofs(c));
            clr_we_o[c] = wen_i && (addr_i == pending_ofs(c));
        end
    end

    // Read multiplexer over summary, views, enables and pending vectors
    always_comb begin
        rdata_o = '0;
        if (addr_i == OFS_SUMMARY) rdata_o[NUM_CH-1:0] = summary_i;
        for (int c = 0; c < NUM_CLASS; c++) begin
            if (addr_i == view_ofs(c))    rdata_o[NUM_CH-1:0] = view_i[c];
            if (addr_i == enable_ofs(c))  rdata_o[NUM_CH-1:0] = en_i[c];
            if (addr_i == pending_ofs(c)) rdata_o[NUM_CH-1:0] = pend_i[c];
        end
    end
endmodule

// File: rtl/dma_irq_ctrl.sv
// Top of the DMA event interrupt controller. Instantiates one class slice
// per event class, the register decode, the per-channel summary and the
// single interrupt output. Assumes NUM_CH <= DATA_W.
module dma_irq_ctrl
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ev_chain_i,
    input  logic [NUM_CH-1:0] ev_node_i,
    input  logic [NUM_CH-1:0] ev_err_a_i,
    input  logic [NUM_CH-1:0] ev_err_b_i,
    input  logic [11:0]       reg_addr_i,
    input  logic              reg_wen_i,
    input  logic [NUM_CH-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    logic [NUM_CLASS-1:0][NUM_CH-1:0] ev_all;
    logic [NUM_CLASS-1:0][NUM_CH-1:0] pend_q;
    logic [NUM_CLASS-1:0][NUM_CH-1:0] en_q;
    logic [NUM_CLASS-1:0][NUM_CH-1:0] view;
    logic [NUM_CLASS-1:0]             en_we;
    logic [NUM_CLASS-1:0]             clr_we;
    logic [NUM_CH-1:0]                summary;

    // Gather event inputs in class order
    always_comb begin
        ev_all[CLS_CHAIN] = ev_chain_i;
        ev_all[CLS_NODE]  = ev_node_i;
        ev_all[CLS_ERR_A] = ev_err_a_i;
        ev_all[CLS_ERR_B] = ev_err_b_i;
    end

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
        dma_irq_class #(.NUM_CH(NUM_CH)) u_class (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_i     (ev_all[c]),
            .en_we_i  (en_we[c]),
            .clr_we_i (clr_we[c]),
            .wdata_i  (reg_wdata_i),
            .pend_o   (pend_q[c]),
            .en_o     (en_q[c]),
            .view_o   (view[c])
        );
    end

    // Per-channel OR of all enabled views
    always_comb begin
        summary = '0;
        for (int c = 0; c < NUM_CLASS; c++) summary |= view[c];
    end

    dma_irq_regif #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regif (
        .addr_i    (reg_addr_i),
        .wen_i     (reg_wen_i),
        .pend_i    (pend_q),
        .en_i      (en_q),
        .view_i    (view),
        .summary_i (summary),
        .en_we_o   (en_we),
        .clr_we_o  (clr_we),
        .rdata_o   (reg_rdata_o)
    );

    assign irq_o = |summary;
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
// Assertion checker for dma_irq_ctrl, attached by bind. Observes event
// inputs, class state, write strobes and the interrupt line.
module dma_irq_ctrl_chk #(
    parameter int NUM_CH    = 16,
    parameter int NUM_CLASS = 4
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NUM_CLASS-1:0][NUM_CH-1:0] ev_all,
    input logic [NUM_CLASS-1:0][NUM_CH-1:0] pend,
    input logic [NUM_CLASS-1:0][NUM_CH-1:0] en,
    input logic [NUM_CLASS-1:0]             en_we,
    input logic [NUM_CLASS-1:0]             clr_we,
    input logic [NUM_CH-1:0]                wdata,
    input logic                             irq
);
    logic any_enabled;

    // Independent recomputation of "some enabled event is pending"
    always_comb begin
        any_enabled = 1'b0;
        for (int c = 0; c < NUM_CLASS; c++) any_enabled |= |(pend[c] & en[c]);
    end

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_chk
        p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (|ev_all[c]) |=> ((pend[c] & $past(ev_all[c])) == $past(ev_all[c])));
        p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_we[c]) |=> ((pend[c] & $past(pend[c])) == $past(pend[c])));
        p_keep_unwritten_r5: assert property (@(posedge clk) disable iff (!rst_n)
            clr_we[c] |=> ((pend[c] & $past(pend[c] & ~wdata)) == $past(pend[c] & ~wdata)));
        p_enable_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_we[c]) |=> $stable(en[c]));
        p_enable_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
            en_we[c] |=> (en[c] == $past(wdata)));
    end

    p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq == any_enabled);
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en_we, clr_we}));
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(.NUM_CH(NUM_CH), .NUM_CLASS(4)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_all (ev_all),
    .pend   (pend_q),
    .en     (en_q),
    .en_we  (en_we),
    .clr_we (clr_we),
    .wdata  (reg_wdata_i),
    .irq    (irq_o)
);

// File: tb/test_dma_irq_ctrl.sv
// Bench for dma_irq_ctrl on a four-channel build: exhaustive pending x
// enable sweep per class plus directed corner cases.
module test_dma_irq_ctrl;
    localparam int NCH = 4;
    localparam int DW  = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] ev [4];
    logic [11:0]    addr = '0;
    logic           wen = 1'b0;
    logic [NCH-1:0] wdata = '0;
    logic [DW-1:0]  rdata;
    logic           irq;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dma_irq_ctrl #(.NUM_CH(NCH), .DATA_W(DW)) i_dma_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ev_chain_i(ev[0]), .ev_node_i(ev[1]),
        .ev_err_a_i(ev[2]), .ev_err_b_i(ev[3]),
        .reg_addr_i(addr), .reg_wen_i(wen), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [11:0] a_view(int c);   return 12'(12'h004 + 4*c); endfunction
    function automatic logic [11:0] a_en(int c);     return 12'(12'h018 + 4*c); endfunction
    function automatic logic [11:0] a_pend(int c);   return 12'(12'h600 + 8*c); endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [NCH-1:0] d);
        @(negedge clk); addr = a; wdata = d; wen = 1'b1;
        @(negedge clk); wen = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic pulse(input int c, input logic [NCH-1:0] v);
        @(negedge clk); ev[c] = v;
        @(negedge clk); ev[c] = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        for (int c = 0; c < 4; c++) ev[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd(12'h000, d); check(d, 0, "R1 summary");
        for (int c = 0; c < 4; c++) begin
            rd(a_view(c), d); check(d, 0, "R1 view");
            rd(a_en(c), d);   check(d, 0, "R1 enable");
            rd(a_pend(c), d); check(d, 0, "R1 pending");
        end
        check({31'b0, irq}, 0, "R1 irq");

        // R3: only low NUM_CH bits stored, read back
        wr(a_en(0), 4'hF); rd(a_en(0), d); check(d, 32'hF, "R3 enable readback");
        wr(a_en(0), 4'h0);

        // Exhaustive sweep: R2 R4 R7 R8
        for (int c = 0; c < 4; c++) begin
            for (int m = 0; m < 16; m++) begin
                wr(a_en(c), 4'(m));
                for (int r = 0; r < 16; r++) begin
                    pulse(c, 4'(r));
                    rd(a_pend(c), d); check(d, 32'(r), "R2 pending set");
                    rd(a_view(c), d); check(d, 32'(r & m), "R4 view");
                    rd(12'h000, d);   check(d, 32'(r & m), "R7 summary");
                    check({31'b0, irq}, {31'b0, (r & m) != 0}, "R8 irq");
                    wr(a_pend(c), 4'hF);
                end
            end
            wr(a_en(c), 4'h0);
        end

        // R5: partial clear
        pulse(2, 4'hF);
        wr(a_pend(2), 4'h5);
        rd(a_pend(2), d); check(d, 32'hA, "R5 partial clear");
        wr(a_pend(2), 4'hF);

        // R6: event and clear collide on bit 0; bit 1 still clears
        pulse(0, 4'h3);
        @(negedge clk); addr = a_pend(0); wdata = 4'h3; wen = 1'b1; ev[0] = 4'h1;
        @(negedge clk); wen = 1'b0; ev[0] = '0;
        rd(a_pend(0), d); check(d, 32'h1, "R6 event wins over clear");
        wr(a_pend(0), 4'hF);

        // R9: chain and node pending together, cleared independently
        pulse(0, 4'h1); pulse(1, 4'h1); pulse(3, 4'h8);
        wr(a_pend(0), 4'h1);
        rd(a_pend(0), d); check(d, 32'h0, "R9 chain cleared");
        rd(a_pend(1), d); check(d, 32'h1, "R9 node kept");
        rd(a_pend(3), d); check(d, 32'h8, "R9 error-B kept");
        wr(a_pend(1), 4'hF); wr(a_pend(3), 4'hF);

        // R7 cross-class summary
        for (int c = 0; c < 4; c++) wr(a_en(c), 4'hF);
        pulse(0, 4'h1); pulse(1, 4'h2); pulse(2, 4'h4);
        rd(12'h000, d); check(d, 32'h7, "R7 cross-class summary");
        check({31'b0, irq}, 1, "R8 irq cross-class");

        // R10: writes to read-only and unmapped addresses ignored
        wr(12'h000, 4'hF); wr(a_view(0), 4'hF); wr(12'h100, 4'hF); wr(12'h604, 4'hF);
        rd(12'h000, d);   check(d, 32'h7, "R10 summary unchanged");
        rd(a_en(0), d);   check(d, 32'hF, "R10 enable unchanged");
        rd(a_pend(0), d); check(d, 32'h1, "R10 pending unchanged");
        rd(12'h100, d);   check(d, 0, "R10 unmapped reads zero");
        rd(12'h604, d);   check(d, 0, "R10 gap reads zero");

        // R8: disabling everything drops irq while events stay pending
        for (int c = 0; c < 4; c++) wr(a_en(c), 4'h0);
        check({31'b0, irq}, 0, "R8 irq masked off");
        rd(a_pend(1), d); check(d, 32'h2, "R8 pending retained");

        finish_run();
    end
endmodule